// File: doc/BRIEF.md
# Configurable Comb-Plus-Biquad Filter

This block is a streaming fixed-point filter. One datapath covers a family of classic signal-processing functions, and the coefficient set alone selects which one it performs. The family includes the first difference, the running accumulator, the leaky integrator, the moving average, the first-order delay network and the audio comb.

Each accepted sample passes through two stages in turn:
- **Comb stage.** It subtracts a scaled copy of the sample taken a programmable number of steps earlier. The history for this lives in a 32-entry circular buffer.
- **Recursive section.** The comb result then feeds a second-order recursive section. Its two feedback terms are added, not subtracted, and a leading gain scales its whole sum.

The full transfer function is (1 − c1·z^−N)·(b0 + b1·z^−1 + b2·z^−2) / (1/a0 − a1·z^−1 − a2·z^−2).

Software-side logic writes the seven coefficients and the delay through a simple write port. A synchronous clear wipes the filter memory between streams and leaves the coefficients in place.

Top module: `comb_biquad_filter`

## Requirements
- R1: After reset, out_valid and out_sample are 0. The coefficients reset to b0 = a0 = 1.0 (65536) and all others 0, with delay N = 0. With these defaults the block passes each sample through unchanged.
- R2: out_valid is high in exactly the cycle after each accepted sample (in_valid high and clr low), and low in every other cycle. Cycles without an accepted sample do not advance the history or the recursive state.
- R3: The comb output is w[n] = x[n] − c1·x[n−N], with the delay N taken from 0..31. N = 0 uses the current sample, giving (1 − c1)·x[n]. Samples older than the last clear or reset count as zero.
- R4: The recursive output is y[n] = a0·(b0·w[n] + b1·w[n−1] + b2·w[n−2] + a1·y[n−1] + a2·y[n−2]). The feedback terms use the stored, saturated outputs.
- R5: Number formats and rounding:
  - Samples are 16-bit two's complement.
  - Coefficients are 18-bit two's complement with 16 fraction bits, covering −2.0 to just under 2.0.
  - w is the comb value rounded to the nearest integer, with ties toward +infinity. It is held at 18 bits with no loss.
  - The output is a0 times the full-width sum, rounded the same way at 32 fraction bits.
- R6: The write port selects a register by cfg_addr: 0 = c1, 1 = b0, 2 = b1, 3 = b2, 4 = a1, 5 = a2, 6 = a0, 7 = N. For N, the delay is cfg_wdata bits 4:0. A write takes effect from the next accepted sample. A sample accepted in the same cycle as a write still uses the old value.
- R7: clr zeroes the sample history, w[n−1], w[n−2], y[n−1] and y[n−2]. clr has priority over in_valid: a sample presented together with clr is dropped and yields no output. clr leaves the coefficients and N unchanged.
- R8: These coefficient sets give the named filters:
  - First difference: b0 = 1, b1 = −1.
  - Accumulator: b0 = a0 = a1 = 1.
  - Leaky integrator: b0 = α, a1 = 1 − α.
  - Eight-point moving average: b0 = 1/8, a1 = 1, c1 = 1, N = 8.
- R9: An output beyond the 16-bit range saturates to 32767 or −32768, and the saturated value is what feeds back as y[n−1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of the filter memory |
| in_valid | input | 1 | Input sample qualifier |
| in_sample | input | 16 | Signed input sample |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select (see R6) |
| cfg_wdata | input | 18 | Coefficient value or delay |
| out_valid | output | 1 | Output sample qualifier |
| out_sample | output | 16 | Signed, rounded and saturated output sample |

## Verification
The hardest state to reach is a comb tap reaching the far end of the circular buffer: with N = 31 the tap reads the entry about to be overwritten. The stimulus programs N = 31 and streams more than 32 samples so the pointer wraps, and it inserts idle cycles so that a wrong pointer advance would show up. A second hard case is a clear or a coefficient write in the very cycle a sample arrives. The stimulus drives both strobes at once and checks the dropped sample, the old coefficient's use and the zeroed history in the following outputs.

// File: rtl/filt_pkg.sv
// Shared definitions for the comb-plus-biquad filter.
// Assumes: the register select order below is the programming contract.
package filt_pkg;
    // Register select codes of the configuration write port
    typedef enum logic [2:0] {
        REG_C1  = 3'd0,
        REG_B0  = 3'd1,
        REG_B1  = 3'd2,
        REG_B2  = 3'd3,
        REG_A1  = 3'd4,
        REG_A2  = 3'd5,
        REG_A0  = 3'd6,
        REG_DLY = 3'd7
    } cfg_sel_e;

    localparam int NUM_COEF = 7;
    localparam int NUM_SEL  = 8;
endpackage

// File: rtl/filt_round_sat.sv
// Round-to-nearest (ties toward +infinity) and saturation.
// Drops SHIFT fraction bits from a signed value and clamps the result to OUT_W
// signed bits. Assumes the input has at least one bit of headroom above the
// rounded result, so the rounding increment cannot wrap.
module filt_round_sat #(
    parameter int IN_W  = 35,
    parameter int SHIFT = 16,
    parameter int OUT_W = 18
) (
    input  logic signed [IN_W-1:0]  din,
    output logic signed [OUT_W-1:0] dout
);
    localparam int Q_W = IN_W - SHIFT;
    localparam logic [OUT_W-1:0] MAXV = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] MINV = {1'b1, {(OUT_W-1){1'b0}}};

    logic [Q_W-1:0]       q;
    logic [Q_W-OUT_W:0]   hi;
    logic                 in_range;
    logic                 frac_unused;

    // floor of the scaled value plus the half bit gives round half up
    assign q           = din[IN_W-1:SHIFT] + {{(Q_W-1){1'b0}}, din[SHIFT-1]};
    assign frac_unused = ^din[SHIFT-2:0];
    assign hi          = q[Q_W-1:OUT_W-1];
    assign in_range    = (&hi) | ~(|hi);

    // pick the rounded value or the clamp limit of the matching sign
    always_comb begin
        if (in_range)
            dout = q[OUT_W-1:0];
        else if (q[Q_W-1])
            dout = MINV;
        else
            dout = MAXV;
    end
endmodule

// File: rtl/filt_coef_bank.sv
// Coefficient and delay register bank.
// Holds seven signed coefficients and the comb delay. A write lands at the
// clock edge, so consumers see the new value from the next cycle on. Reset
// loads a unity pass-through set (b0 = a0 = 1.0, others 0, delay 0).
module filt_coef_bank
    import filt_pkg::*;
#(
    parameter int COEF_W = 18,
    parameter int FRAC   = 16,
    parameter int DLY_W  = 5,
    parameter int NCOEF  = NUM_COEF,
    parameter int AW     = $clog2(NUM_SEL)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [AW-1:0]                 addr,
    input  logic [COEF_W-1:0]             wdata,
    output logic [NCOEF-1:0][COEF_W-1:0]  coef,
    output logic [DLY_W-1:0]              dly
);
    localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << FRAC;

    generate
        for (genvar i = 0; i < NCOEF; i++) begin : g_coef
            localparam logic [COEF_W-1:0] INIT =
                (i == int'(REG_B0) || i == int'(REG_A0)) ? UNITY : '0;
            logic [COEF_W-1:0] q;

            // one coefficient register, loaded when its select code is written
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= INIT;
                else if (we && addr == AW'(i))
                    q <= wdata;
            end
            assign coef[i] = q;

            // R6: a write to this select code is held in the register afterwards
            a_r6_coef_write: assert property (@(posedge clk) disable iff (!rst_n)
                (rst_n && we && addr == AW'(i)) |=> (q == $past(wdata)));
        end
    endgenerate

    // comb delay register, low bits of the write data
    always_ff @(posedge clk) begin
        if (!rst_n)
            dly <= '0;
        else if (we && addr == AW'(int'(REG_DLY)))
            dly <= wdata[DLY_W-1:0];
    end
endmodule

// File: rtl/filt_comb.sv
// Comb stage: w[n] = x[n] - c1 * x[n-N].
// Keeps the last DEPTH accepted samples in a circular buffer addressed by a
// write pointer. Delay 0 taps the current sample. The output is combinational
// from the current sample and the stored history. A clear zeroes the history
// and the pointer. Assumes DEPTH is a power of two.
module filt_comb #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 18,
    parameter int FRAC   = 16,
    parameter int DEPTH  = 32,
    parameter int DLY_W  = $clog2(DEPTH),
    parameter int W_W    = DATA_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     accept,
    input  logic signed [DATA_W-1:0] x,
    input  logic signed [COEF_W-1:0] c1,
    input  logic [DLY_W-1:0]         dly,
    output logic signed [W_W-1:0]    w
);
    localparam int PROD_W = COEF_W + DATA_W;
    localparam int DIFF_W = PROD_W + 1;

    logic [DATA_W-1:0]          hist [DEPTH];
    logic [DLY_W-1:0]           ptr;
    logic [DLY_W-1:0]           rd_idx;
    logic signed [DATA_W-1:0]   x_tap;
    logic signed [PROD_W-1:0]   prod;
    logic signed [DIFF_W-1:0]   diff;

    // tap address: the slot written N accepted samples ago
    assign rd_idx = ptr - dly;

    // delay 0 taps the live sample, otherwise the stored one
    always_comb begin
        if (dly == '0)
            x_tap = x;
        else
            x_tap = hist[rd_idx];
    end

    assign prod = c1 * x_tap;
    assign diff = {{(DIFF_W-DATA_W-FRAC){x[DATA_W-1]}}, x, {FRAC{1'b0}}}
                - {prod[PROD_W-1], prod};

    filt_round_sat #(
        .IN_W  (DIFF_W),
        .SHIFT (FRAC),
        .OUT_W (W_W)
    ) u_round (
        .din  (diff),
        .dout (w)
    );

    // history write and pointer advance per accepted sample; clear wipes all
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ptr <= '0;
            for (int k = 0; k < DEPTH; k++)
                hist[k] <= '0;
        end else if (accept) begin
            hist[ptr] <= x;
            ptr       <= ptr + DLY_W'(1);
        end
    end

    // R2: the pointer moves one slot per accepted sample, never otherwise
    a_r2_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !clr && accept) |=> (ptr == $past(ptr) + DLY_W'(1)));
    a_r2_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !clr && !accept) |=> $stable(ptr));
    // R7: a clear restarts the buffer at slot zero
    a_r7_clear_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && clr) |=> (ptr == '0));
endmodule

// File: rtl/filt_biquad.sv
// Second-order recursive section with added feedback and a leading gain:
// y[n] = a0 * (b0 w[n] + b1 w[n-1] + b2 w[n-2] + a1 y[n-1] + a2 y[n-2]).
// The sum is kept at full width. The a0 product is rounded once at 2*FRAC
// fraction bits and saturated to DATA_W. State advances only on an accepted
// sample and is zeroed by a clear.
module filt_biquad #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 18,
    parameter int FRAC   = 16,
    parameter int W_W    = DATA_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     accept,
    input  logic signed [W_W-1:0]    w,
    input  logic signed [COEF_W-1:0] b0,
    input  logic signed [COEF_W-1:0] b1,
    input  logic signed [COEF_W-1:0] b2,
    input  logic signed [COEF_W-1:0] a1,
    input  logic signed [COEF_W-1:0] a2,
    input  logic signed [COEF_W-1:0] a0,
    output logic signed [DATA_W-1:0] y
);
    localparam int PW_W  = COEF_W + W_W;
    localparam int PY_W  = COEF_W + DATA_W;
    localparam int S_W   = PW_W + 3;
    localparam int FIN_W = COEF_W + S_W;

    logic signed [W_W-1:0]    w1, w2;
    logic signed [DATA_W-1:0] y1, y2;
    logic signed [PW_W-1:0]   pb0, pb1, pb2;
    logic signed [PY_W-1:0]   pa1, pa2;
    logic signed [S_W-1:0]    acc;
    logic signed [FIN_W-1:0]  fin;

    assign pb0 = b0 * w;
    assign pb1 = b1 * w1;
    assign pb2 = b2 * w2;
    assign pa1 = a1 * y1;
    assign pa2 = a2 * y2;

    // full-width sum of the five taps, feedback added
    assign acc = S_W'(pb0) + S_W'(pb1) + S_W'(pb2) + S_W'(pa1) + S_W'(pa2);
    assign fin = a0 * acc;

    filt_round_sat #(
        .IN_W  (FIN_W),
        .SHIFT (2 * FRAC),
        .OUT_W (DATA_W)
    ) u_round (
        .din  (fin),
        .dout (y)
    );

    // delay-line update per accepted sample; clear zeroes the state
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            w1 <= '0;
            w2 <= '0;
            y1 <= '0;
            y2 <= '0;
        end else if (accept) begin
            w1 <= w;
            w2 <= w1;
            y1 <= y;
            y2 <= y1;
        end
    end

    // R7: a clear leaves every state register at zero
    a_r7_state_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && clr) |=> (w1 == '0 && w2 == '0 && y1 == '0 && y2 == '0));
    // R4: the older taps take the previous newer taps on each accepted sample
    a_r4_history_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !clr && accept) |=> (y2 == $past(y1) && w2 == $past(w1)));
    // R2: without an accepted sample the recursion holds still
    a_r2_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !clr && !accept) |=> ($stable(y1) && $stable(w1)));
endmodule

// File: rtl/comb_biquad_filter.sv
// Top of the configurable comb-plus-biquad filter.
// A comb stage feeds a second-order recursive section. The whole arithmetic
// path is evaluated in the cycle a sample is accepted, and the rounded result
// is registered, so the output appears one clock later. Coefficient writes take
// effect from the next accepted sample. clr has priority over in_valid.
module comb_biquad_filter
    import filt_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int COEF_W = 18,
    parameter int FRAC   = 16,
    parameter int DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [COEF_W-1:0] cfg_wdata,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_sample
);
    localparam int DLY_W = $clog2(DEPTH);
    localparam int W_W   = DATA_W + 2;
    localparam int AW    = $clog2(NUM_SEL);

    logic                           accept;
    logic [NUM_COEF-1:0][COEF_W-1:0] coef;
    logic [DLY_W-1:0]               dly;
    logic signed [W_W-1:0]          w;
    logic signed [DATA_W-1:0]       y;

    assign accept = in_valid & ~clr;

    filt_coef_bank #(
        .COEF_W (COEF_W),
        .FRAC   (FRAC),
        .DLY_W  (DLY_W),
        .NCOEF  (NUM_COEF),
        .AW     (AW)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .coef  (coef),
        .dly   (dly)
    );

    filt_comb #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W),
        .FRAC   (FRAC),
        .DEPTH  (DEPTH),
        .DLY_W  (DLY_W),
        .W_W    (W_W)
    ) u_comb (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .accept (accept),
        .x      (in_sample),
        .c1     (coef[int'(REG_C1)]),
        .dly    (dly),
        .w      (w)
    );

    filt_biquad #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W),
        .FRAC   (FRAC),
        .W_W    (W_W)
    ) u_iir (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .accept (accept),
        .w      (w),
        .b0     (coef[int'(REG_B0)]),
        .b1     (coef[int'(REG_B1)]),
        .b2     (coef[int'(REG_B2)]),
        .a1     (coef[int'(REG_A1)]),
        .a2     (coef[int'(REG_A2)]),
        .a0     (coef[int'(REG_A0)]),
        .y      (y)
    );

    // output register: one result per accepted sample, held in between
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= accept;
            if (accept)
                out_sample <= y;
        end
    end

    // R2: every accepted sample yields a result on the next cycle
    a_r2_out_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && in_valid && !clr) |=> out_valid);
    // R2, R7: no result without an accepted sample (clr drops the sample)
    a_r2_no_spurious_out: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !(in_valid && !clr)) |=> (!out_valid && $stable(out_sample)));
endmodule

// File: tb/sim_comb_biquad_filter.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver computes each expected output with an
// independent arithmetic model and queues it; the monitor compares results.
module sim_comb_biquad_filter;
    localparam int A_C1 = 0, A_B0 = 1, A_B1 = 2, A_B2 = 3,
                   A_A1 = 4, A_A2 = 5, A_A0 = 6, A_N = 7;
    localparam longint ONE = 65536;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [17:0] cfg_wdata = '0;
    logic        out_valid;
    logic [15:0] out_sample;

    comb_biquad_filter u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
        .in_sample(in_sample), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .out_valid(out_valid), .out_sample(out_sample)
    );

    always #2.5 clk = ~clk;

    int     n_tests = 0;
    int     n_fail  = 0;
    longint exp_q[$];
    string  tag_q[$];
    int unsigned seed = 32'h1234_5678;

    // reference model state
    longint xh [32];
    longint mw1, mw2, my1, my2;
    longint mc1, mb0, mb1, mb2, ma1, ma2, ma0;
    int     mn;

    function automatic longint sat(longint v, int bits);
        longint hi = (longint'(1) <<< (bits - 1)) - 1;
        longint lo = -(longint'(1) <<< (bits - 1));
        return (v > hi) ? hi : ((v < lo) ? lo : v);
    endfunction

    function automatic longint rnd(longint v, int sh);
        return (v + (longint'(1) <<< (sh - 1))) >>> sh;
    endfunction

    function automatic longint model_step(longint x);
        longint tap, w, s, y;
        tap = (mn == 0) ? x : xh[mn];
        w   = sat(rnd((x <<< 16) - mc1 * tap, 16), 18);
        s   = mb0 * w + mb1 * mw1 + mb2 * mw2 + ma1 * my1 + ma2 * my2;
        y   = sat(rnd(ma0 * s, 32), 16);
        for (int k = 31; k >= 2; k--) xh[k] = xh[k-1];
        xh[1] = x;
        mw2 = mw1; mw1 = w; my2 = my1; my1 = y;
        return y;
    endfunction

    function automatic void model_clear();
        for (int k = 0; k < 32; k++) xh[k] = 0;
        mw1 = 0; mw2 = 0; my1 = 0; my2 = 0;
    endfunction

    function automatic void model_write(int a, longint d);
        case (a)
            A_C1: mc1 = d;
            A_B0: mb0 = d;
            A_B1: mb1 = d;
            A_B2: mb2 = d;
            A_A1: ma1 = d;
            A_A2: ma2 = d;
            A_A0: ma0 = d;
            default: mn = int'(d & 31);
        endcase
    endfunction

    function automatic longint rand16();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return longint'($signed(seed[31:16]));
    endfunction

    task automatic check(bit ok, string tag, longint act, longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // one input cycle: drive at the falling edge, update the model to match
    task automatic cycle(bit v, longint x, bit we, int a, longint d, bit c, string tag);
        @(negedge clk);
        in_valid  = v;
        in_sample = x[15:0];
        cfg_we    = we;
        cfg_addr  = a[2:0];
        cfg_wdata = d[17:0];
        clr       = c;
        if (c) model_clear();
        else if (v) begin
            exp_q.push_back(model_step(x));
            tag_q.push_back(tag);
        end
        if (we) model_write(a, d);
    endtask

    task automatic send(longint x, string tag);
        cycle(1'b1, x, 1'b0, 0, 0, 1'b0, tag);
    endtask

    task automatic wr(int a, longint d);
        cycle(1'b0, 0, 1'b1, a, d, 1'b0, "");
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 0, 1'b0, 0, 0, 1'b0, "");
    endtask

    task automatic do_clear();
        cycle(1'b0, 0, 1'b0, 0, 0, 1'b1, "");
    endtask

    // monitor: pop one expected value per produced result
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 output without accepted sample",
                      longint'($signed(out_sample)), 0);
            end else begin
                longint e;
                string  t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(longint'($signed(out_sample)) == e, t,
                      longint'($signed(out_sample)), e);
            end
        end
    end

    // watchdog: a hung run is a failure and still reports
    initial begin
        repeat (50000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        model_clear();
        mc1 = 0; mb0 = ONE; mb1 = 0; mb2 = 0; ma1 = 0; ma2 = 0; ma0 = ONE; mn = 0;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        check(out_sample == 16'd0, "R1 out_sample in reset", out_sample, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);

        // R1: default pass-through
        send(100, "R1 default passthrough");
        send(-200, "R1 default passthrough");
        send(32767, "R1 default passthrough");
        send(-32768, "R1 default passthrough");
        idle(1);
        idle(1);
        check(out_valid == 1'b0, "R2 no output while idle", out_valid, 0);

        // R8: first difference, with gaps in the stream (R2)
        wr(A_B1, -ONE);
        for (int i = 0; i < 10; i++) begin
            send(rand16() >>> 2, "R8 first difference");
            if (i % 3 == 0) idle(2);
        end

        // R8: accumulator, then R9 saturation both ways
        do_clear();
        wr(A_B1, 0);
        wr(A_A1, ONE);
        for (int i = 0; i < 8; i++) send(i * 37 - 100, "R8 accumulator");
        for (int i = 0; i < 4; i++) send(20000, "R9 saturation high");
        for (int i = 0; i < 5; i++) send(-30000, "R9 saturation low");

        // R7: clear together with a sample drops it and wipes the state
        cycle(1'b1, 12345, 1'b0, 0, 0, 1'b1, "");
        idle(1);
        check(out_valid == 1'b0, "R7 sample with clr dropped", out_valid, 0);
        check(exp_q.size() == 0, "R7 nothing pending after clr", exp_q.size(), 0);
        send(7, "R7 coefficients kept after clear");
        send(9, "R7 coefficients kept after clear");

        // R8: leaky integrator, alpha = 0.25
        do_clear();
        wr(A_A1, 49152);
        wr(A_B0, 16384);
        for (int i = 0; i < 12; i++) send(1000, "R8 leaky integrator");

        // R8: eight-point moving average
        do_clear();
        wr(A_A1, ONE);
        wr(A_B0, 8192);
        wr(A_C1, ONE);
        wr(A_N, 8);
        for (int i = 0; i < 12; i++) send(800, "R8 moving average step");
        for (int i = 0; i < 20; i++) send(rand16(), "R8 moving average random");

        // R3, R5: delay 0 and rounding ties toward +infinity
        do_clear();
        wr(A_A1, 0);
        wr(A_B0, ONE);
        wr(A_C1, 32768);
        wr(A_N, 0);
        send(3, "R5 tie rounds up");
        send(-3, "R5 tie rounds up");
        send(5, "R3 delay zero");
        send(-5, "R3 delay zero");
        send(-1, "R5 tie rounds up");
        send(1, "R5 tie rounds up");

        // R3: deepest delay, pointer wraps, with gaps (R2)
        do_clear();
        wr(A_C1, -32768);
        wr(A_N, 31);
        for (int i = 0; i < 45; i++) begin
            send(rand16(), "R3 comb depth 31");
            if (i == 20) idle(3);
        end

        // R7: after a clear the history reads as zero
        do_clear();
        wr(A_C1, ONE);
        wr(A_N, 5);
        for (int i = 0; i < 8; i++) send(1000 + i, "R7 history cleared");

        // R6: a write in the same cycle as a sample applies to the next one
        cycle(1'b1, 1000, 1'b1, A_B0, 32768, 1'b0, "R6 same-cycle write uses old value");
        send(1000, "R6 new coefficient applied");

        // R4: full second-order section with every tap and gain active
        do_clear();
        wr(A_B0, 20000);
        wr(A_B1, -30000);
        wr(A_B2, 12000);
        wr(A_A1, 40000);
        wr(A_A2, -20000);
        wr(A_A0, 49152);
        wr(A_C1, 16384);
        wr(A_N, 3);
        for (int i = 0; i < 40; i++) send(rand16() >>> 1, "R4 full recursion");

        // R9: gain of -2.0 drives the output to both limits
        do_clear();
        wr(A_B1, 0); wr(A_B2, 0); wr(A_A1, 0); wr(A_A2, 0); wr(A_C1, 0);
        wr(A_B0, ONE);
        wr(A_A0, -131072);
        send(20000, "R9 negative gain clamp");
        send(-20000, "R9 negative gain clamp");
        send(1234, "R9 negative gain in range");

        idle(3);
        check(exp_q.size() == 0, "R2 every sample produced an output", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule